// File: doc/BRIEF.md
# Register compare and flag ALU

This block is the execute stage for a 16-bit-opcode RISC core's two-register arithmetic and compare group. It also covers a few single-register operations: decrement-and-test, and the sign tests against zero. Each accepted opcode arrives with two 32-bit operands, Rn and Rm. One clock later the block presents the value to write back into Rn, a write-enable and the updated status bit T.

T is the only status bit the block keeps. It lives in an internal register. Depending on the operation, T holds a compare result, a carry, a borrow or a signed-overflow indication. All arithmetic and compares share one adder. A control record decoded from the opcode steers that adder.

The compare of R0 against an immediate is handled the same way as the other single-operand cases. The caller presents R0 on the Rn operand port, and the 8-bit immediate is taken from the opcode. Register numbers inside the opcode are ignored here, because the register file sits outside the block.

Top module: `cmp_flag_alu`

## Requirements
- R1: While reset is held and right after it, rn_we_o, illegal_o, t_flag_o and rn_wdata_o are all zero.
- R2: Opcodes 0011xxxxxxxxLLLL compare Rn with Rm and write only T, never Rn. LLLL=0000 tests equal. LLLL=0010 tests unsigned Rn>=Rm. LLLL=0011 tests signed Rn>=Rm. LLLL=0110 tests unsigned Rn>Rm. LLLL=0111 tests signed Rn>Rm.
- R3: In the 0011 group, LLLL=1100 writes Rn+Rm and LLLL=1000 writes Rn-Rm. Both leave T unchanged.
- R4: In the 0011 group, LLLL=1110 writes Rn+Rm+T and puts the carry out into T. LLLL=1010 writes Rn-Rm-T and puts the borrow into T.
- R5: In the 0011 group, LLLL=1111 writes Rn+Rm and LLLL=1011 writes Rn-Rm. T becomes 1 on signed overflow and 0 otherwise.
- R6: Opcode 0100xxxx00010000 writes Rn-1. T is 1 exactly when that result is zero.
- R7: Opcode 0100xxxx00010001 sets T to (Rn >= 0, signed). Opcode 0100xxxx00010101 sets T to (Rn > 0, signed). Neither writes Rn.
- R8: Opcode 10001000iiiiiiii sets T when the Rn port (carrying R0) equals the sign-extended 8-bit immediate. It does not write Rn.
- R9: Any other opcode raises illegal_o for one cycle. It leaves T unchanged and does not assert rn_we_o. This includes 0011 group nibbles 0001, 0100, 0101, 1001 and 1101.
- R10: Results appear in the cycle after op_valid is sampled high. In a cycle after op_valid is sampled low, rn_we_o and illegal_o are low and T holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 16 | Instruction word |
| rn_val | input | DATA_W | Rn operand (R0 for the immediate compare) |
| rm_val | input | DATA_W | Rm operand |
| rn_wdata_o | output | DATA_W | Value to write into Rn |
| rn_we_o | output | 1 | Rn write strobe, one cycle |
| t_flag_o | output | 1 | Current T bit |
| illegal_o | output | 1 | Unrecognised opcode, one cycle |

## Verification
The bench drives every operation with the operand corners 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and pairs them with each other. These pairs separate signed from unsigned compares. A design that swapped the two would disagree on pairs such as 0x80000000 against 1, and one that mixed up higher with higher-or-same would fail on equal operands.

The bench runs carry, borrow and overflow operations with T both cleared and set. An inverted borrow, or a T input that is ignored, shows up in the result word. An overflow check built from the wrong operand signs flags MIN-1 or MAX+1 incorrectly.

Decrement of 1 must give T=1. Immediates 0x80 and 0xFF must sign-extend. Illegal and idle cycles must leave a set T untouched.

// File: rtl/cfalu_pkg.sv
package cfalu_pkg;

    localparam int OPC_W = 16;
    localparam int IMM_W = 8;

    typedef enum logic [3:0] {
        OP_ILLEGAL,
        OP_CMPEQ,
        OP_CMPHS,
        OP_CMPGE,
        OP_CMPHI,
        OP_CMPGT,
        OP_SUB,
        OP_ADD,
        OP_SUBC,
        OP_ADDC,
        OP_SUBV,
        OP_ADDV,
        OP_DEC,
        OP_NONNEG,
        OP_POS,
        OP_EQIMM
    } alu_op_e;

    // Control record steering the shared adder and the T selector
    typedef struct packed {
        alu_op_e op;
        logic    sub;     // invert B and use the inverted carry-in
        logic    use_t;   // feed T into the carry chain
        logic    b_one;   // B operand is the constant one
        logic    b_imm;   // B operand is the sign-extended immediate
        logic    wr_rn;   // result goes back to Rn
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input logic [OPC_W-1:0] opc);
        alu_ctl_t c;
        c = '{op: OP_ILLEGAL, sub: 1'b0, use_t: 1'b0, b_one: 1'b0,
              b_imm: 1'b0, wr_rn: 1'b0};
        if (opc[15:12] == 4'h3) begin
            case (opc[3:0])
                4'h0: begin c.op = OP_CMPEQ; c.sub = 1'b1; end
                4'h2: begin c.op = OP_CMPHS; c.sub = 1'b1; end
                4'h3: begin c.op = OP_CMPGE; c.sub = 1'b1; end
                4'h6: begin c.op = OP_CMPHI; c.sub = 1'b1; end
                4'h7: begin c.op = OP_CMPGT; c.sub = 1'b1; end
                4'h8: begin c.op = OP_SUB;  c.sub = 1'b1; c.wr_rn = 1'b1; end
                4'hC: begin c.op = OP_ADD;  c.wr_rn = 1'b1; end
                4'hA: begin c.op = OP_SUBC; c.sub = 1'b1; c.use_t = 1'b1; c.wr_rn = 1'b1; end
                4'hE: begin c.op = OP_ADDC; c.use_t = 1'b1; c.wr_rn = 1'b1; end
                4'hB: begin c.op = OP_SUBV; c.sub = 1'b1; c.wr_rn = 1'b1; end
                4'hF: begin c.op = OP_ADDV; c.wr_rn = 1'b1; end
                default: c.op = OP_ILLEGAL;
            endcase
        end else if (opc[15:12] == 4'h4) begin
            case (opc[7:0])
                8'h10: begin c.op = OP_DEC; c.sub = 1'b1; c.b_one = 1'b1; c.wr_rn = 1'b1; end
                8'h11: c.op = OP_NONNEG;
                8'h15: c.op = OP_POS;
                default: c.op = OP_ILLEGAL;
            endcase
        end else if (opc[15:8] == 8'h88) begin
            c.op    = OP_EQIMM;
            c.sub   = 1'b1;
            c.b_imm = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfalu_decode.sv
module cfalu_decode
    import cfalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  opcode,
    output alu_ctl_t          ctl,
    output logic [DATA_W-1:0] imm_ext
);
    localparam int EXT_W = DATA_W - IMM_W;

    always_comb begin
        ctl     = decode_op(opcode);
        imm_ext = {{EXT_W{opcode[IMM_W-1]}}, opcode[IMM_W-1:0]};
    end
endmodule

// File: rtl/cfalu_addsub.sv
module cfalu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c0;

    always_comb begin
        b_eff       = sub ? ~b : b;
        c0          = sub ? ~cin : cin;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
        ovf         = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/cfalu_tsel.sv
module cfalu_tsel
    import cfalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] sum,
    input  logic              cout,
    input  logic              ovf,
    input  logic              t_cur,
    output logic              t_next
);
    localparam int MSB = DATA_W - 1;

    logic eq;
    logic sge;

    always_comb begin
        eq  = (a == b);
        sge = ~(sum[MSB] ^ ovf);
        case (op)
            OP_CMPEQ, OP_EQIMM: t_next = eq;
            OP_CMPHS:           t_next = cout;
            OP_CMPGE:           t_next = sge;
            OP_CMPHI:           t_next = cout & ~eq;
            OP_CMPGT:           t_next = sge & ~eq;
            OP_ADDC:            t_next = cout;
            OP_SUBC:            t_next = ~cout;
            OP_ADDV, OP_SUBV:   t_next = ovf;
            OP_DEC:             t_next = (sum == '0);
            OP_NONNEG:          t_next = ~a[MSB];
            OP_POS:             t_next = ~a[MSB] & (|a);
            default:            t_next = t_cur;
        endcase
    end
endmodule

// File: rtl/cmp_flag_alu.sv
module cmp_flag_alu
    import cfalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] rm_val,
    output logic [DATA_W-1:0] rn_wdata_o,
    output logic              rn_we_o,
    output logic              t_flag_o,
    output logic              illegal_o
);
    alu_ctl_t          ctl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_sel;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              ovf;
    logic              t_next;
    logic              t_q;

    cfalu_decode #(.DATA_W(DATA_W)) u_dec (
        .opcode  (opcode),
        .ctl     (ctl),
        .imm_ext (imm_ext)
    );

    always_comb begin
        if (ctl.b_imm)
            b_sel = imm_ext;
        else if (ctl.b_one)
            b_sel = DATA_W'(1);
        else
            b_sel = rm_val;
    end

    cfalu_addsub #(.DATA_W(DATA_W)) u_add (
        .a    (rn_val),
        .b    (b_sel),
        .sub  (ctl.sub),
        .cin  (ctl.use_t & t_q),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    cfalu_tsel #(.DATA_W(DATA_W)) u_tsel (
        .op     (ctl.op),
        .a      (rn_val),
        .b      (b_sel),
        .sum    (sum),
        .cout   (cout),
        .ovf    (ovf),
        .t_cur  (t_q),
        .t_next (t_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q        <= 1'b0;
            rn_we_o    <= 1'b0;
            illegal_o  <= 1'b0;
            rn_wdata_o <= '0;
        end else begin
            rn_we_o   <= 1'b0;
            illegal_o <= 1'b0;
            if (op_valid) begin
                t_q       <= t_next;
                illegal_o <= (ctl.op == OP_ILLEGAL);
                if (ctl.wr_rn) begin
                    rn_we_o    <= 1'b1;
                    rn_wdata_o <= sum;
                end
            end
        end
    end

    assign t_flag_o = t_q;
endmodule

// File: rtl/cfalu_chk.sv
module cfalu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [15:0]       opcode,
    input logic [DATA_W-1:0] rn_val,
    input logic [DATA_W-1:0] rm_val,
    input logic [DATA_W-1:0] rn_wdata_o,
    input logic              rn_we_o,
    input logic              t_flag_o,
    input logic              illegal_o
);
    // R10: an idle cycle produces no strobes and keeps T
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(op_valid) |-> (!rn_we_o && !illegal_o && t_flag_o == $past(t_flag_o)));

    // R9: an illegal opcode never writes and keeps T
    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rn_we_o && t_flag_o == $past(t_flag_o)));

    // R3: plain add/sub writes Rn, keeps T, and the sum matches for add
    p_addsub_keep_t_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(op_valid) && $past(opcode[15:12]) == 4'h3 && $past(opcode[3])
         && $past(opcode[1:0]) == 2'b00)
        |-> (rn_we_o && t_flag_o == $past(t_flag_o)));

    p_add_value_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(op_valid) && $past(opcode[15:12]) == 4'h3 && $past(opcode[3:0]) == 4'hC)
        |-> (rn_wdata_o == $past(rn_val) + $past(rm_val)));

    // R2: the five compares never write Rn
    p_cmp_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(op_valid) && $past(opcode[15:12]) == 4'h3
         && ($past(opcode[3:0]) == 4'h0 || $past(opcode[3:0]) == 4'h2
          || $past(opcode[3:0]) == 4'h3 || $past(opcode[3:0]) == 4'h6
          || $past(opcode[3:0]) == 4'h7))
        |-> (!rn_we_o && !illegal_o));

    // R6: decrement sets T exactly on a zero result
    p_dec_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(op_valid) && $past(opcode[15:12]) == 4'h4 && $past(opcode[7:0]) == 8'h10)
        |-> (rn_we_o && t_flag_o == (rn_wdata_o == '0)));
endmodule

bind cmp_flag_alu cfalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .rn_val     (rn_val),
    .rm_val     (rm_val),
    .rn_wdata_o (rn_wdata_o),
    .rn_we_o    (rn_we_o),
    .t_flag_o   (t_flag_o),
    .illegal_o  (illegal_o)
);

// File: tb/cmp_flag_alu_bench.sv
`timescale 1ns/1ps
module cmp_flag_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = 16'h0;
    logic [31:0] rn_val = 32'h0;
    logic [31:0] rm_val = 32'h0;
    logic [31:0] rn_wdata_o;
    logic        rn_we_o;
    logic        t_flag_o;
    logic        illegal_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  exp_t    = 1'b0;
    bit  done     = 1'b0;
    logic [31:0] corner [5];

    always #4 clk = ~clk;

    cmp_flag_alu u_cmp_flag_alu (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .rn_val     (rn_val),
        .rm_val     (rm_val),
        .rn_wdata_o (rn_wdata_o),
        .rn_we_o    (rn_we_o),
        .t_flag_o   (t_flag_o),
        .illegal_o  (illegal_o)
    );

    // Register fields in the opcode are irrelevant to this block
    function automatic logic [15:0] grp3(input logic [3:0] low);
        return {4'h3, 4'h1, 4'h2, low};
    endfunction

    // Reference model: {illegal, we, t, result}
    function automatic logic [34:0] model(input logic [15:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input bit t);
        logic        ill = 1'b0;
        logic        we  = 1'b0;
        logic        tn  = t;
        logic [31:0] res = 32'h0;
        logic [32:0] w;
        longint      s;
        if (op[15:12] == 4'h3) begin
            case (op[3:0])
                4'h0: tn = (a == b);
                4'h2: tn = (a >= b);
                4'h3: tn = ($signed(a) >= $signed(b));
                4'h6: tn = (a > b);
                4'h7: tn = ($signed(a) > $signed(b));
                4'h8: begin res = a - b; we = 1'b1; end
                4'hC: begin res = a + b; we = 1'b1; end
                4'hE: begin w = {1'b0, a} + {1'b0, b} + {32'h0, t}; res = w[31:0]; tn = w[32]; we = 1'b1; end
                4'hA: begin w = {1'b0, a} - {1'b0, b} - {32'h0, t}; res = w[31:0]; tn = w[32]; we = 1'b1; end
                4'hF: begin
                    res = a + b; we = 1'b1;
                    s = longint'($signed(a)) + longint'($signed(b));
                    tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                end
                4'hB: begin
                    res = a - b; we = 1'b1;
                    s = longint'($signed(a)) - longint'($signed(b));
                    tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                end
                default: ill = 1'b1;
            endcase
        end else if (op[15:12] == 4'h4) begin
            case (op[7:0])
                8'h10: begin res = a - 32'd1; we = 1'b1; tn = (res == 32'h0); end
                8'h11: tn = ($signed(a) >= 0);
                8'h15: tn = ($signed(a) > 0);
                default: ill = 1'b1;
            endcase
        end else if (op[15:8] == 8'h88) begin
            tn = (a == {{24{op[7]}}, op[7:0]});
        end else begin
            ill = 1'b1;
        end
        if (ill) tn = t;
        return {ill, we, tn, res};
    endfunction

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got ill/we/t/data=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the result
    task automatic run_op(input string req, input logic [15:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        logic [34:0] e;
        logic [31:0] d;
        e = model(op, a, b, exp_t);
        op_valid = 1'b1;
        opcode   = op;
        rn_val   = a;
        rm_val   = b;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        d = rn_we_o ? rn_wdata_o : 32'h0;
        if (!e[33]) e[31:0] = 32'h0;
        check(req, {illegal_o, rn_we_o, t_flag_o, d}, e);
        exp_t = e[32];
    endtask

    task automatic set_t(input bit v);
        run_op("R2", grp3(4'h0), 32'h0, v ? 32'h0 : 32'h1);
    endtask

    task automatic t_reset;
        check("R1", {illegal_o, rn_we_o, t_flag_o, rn_wdata_o}, 35'h0);
    endtask

    task automatic t_compares;
        logic [3:0] lows [5] = '{4'h0, 4'h2, 4'h3, 4'h6, 4'h7};
        foreach (lows[k])
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_op("R2", grp3(lows[k]), corner[i], corner[j]);
    endtask

    task automatic t_addsub;
        for (int tv = 0; tv < 2; tv++) begin
            set_t(bit'(tv));
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) begin
                    run_op("R3", grp3(4'hC), corner[i], corner[j]);
                    run_op("R3", grp3(4'h8), corner[i], corner[j]);
                end
        end
    endtask

    task automatic t_carry;
        for (int tv = 0; tv < 2; tv++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) begin
                    set_t(bit'(tv));
                    run_op("R4", grp3(4'hE), corner[i], corner[j]);
                    set_t(bit'(tv));
                    run_op("R4", grp3(4'hA), corner[i], corner[j]);
                end
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                set_t(1'b1);
                run_op("R5", grp3(4'hF), corner[i], corner[j]);
                set_t(1'b1);
                run_op("R5", grp3(4'hB), corner[i], corner[j]);
            end
    endtask

    task automatic t_dec;
        for (int i = 0; i < 5; i++) begin
            set_t(1'b0);
            run_op("R6", 16'h4310, corner[i], 32'h0);
            set_t(1'b1);
            run_op("R6", 16'h4310, corner[i], 32'h0);
        end
        run_op("R6", 16'h4310, 32'h2, 32'h0);
    endtask

    task automatic t_sign;
        for (int i = 0; i < 5; i++)
            for (int tv = 0; tv < 2; tv++) begin
                set_t(bit'(tv));
                run_op("R7", 16'h4511, corner[i], 32'h5);
                set_t(bit'(tv));
                run_op("R7", 16'h4515, corner[i], 32'h5);
            end
    endtask

    task automatic t_imm;
        logic [7:0] imms [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        foreach (imms[k])
            for (int i = 0; i < 5; i++)
                run_op("R8", {8'h88, imms[k]}, corner[i], 32'h0);
        run_op("R8", 16'h8880, 32'hFFFF_FF80, 32'h0);
        run_op("R8", 16'h8880, 32'h0000_0080, 32'h0);
    endtask

    task automatic t_illegal;
        logic [15:0] bad [7] = '{16'h3121, 16'h3124, 16'h3125, 16'h3129,
                                 16'h312D, 16'h4112, 16'h8900};
        foreach (bad[k]) begin
            set_t(1'b1);
            run_op("R9", bad[k], 32'h1234_5678, 32'h1);
            check("R9", {illegal_o, rn_we_o, t_flag_o, 32'h0}, {1'b1, 1'b0, 1'b1, 32'h0});
            @(posedge clk);
            @(negedge clk);
            check("R9", {illegal_o, rn_we_o, t_flag_o, 32'h0}, {1'b0, 1'b0, 1'b1, 32'h0});
        end
    endtask

    task automatic t_idle;
        for (int tv = 0; tv < 2; tv++) begin
            set_t(bit'(tv));
            op_valid = 1'b0;
            opcode   = 16'h4310;
            rn_val   = 32'h1;
            @(posedge clk);
            @(negedge clk);
            check("R10", {illegal_o, rn_we_o, t_flag_o, 32'h0},
                  {1'b0, 1'b0, exp_t, 32'h0});
        end
        // back-to-back ops: each result lands one cycle later
        run_op("R10", grp3(4'hC), 32'd5, 32'd7);
        run_op("R10", grp3(4'h8), 32'd5, 32'd7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        corner[0] = 32'h0000_0000;
        corner[1] = 32'h0000_0001;
        corner[2] = 32'h7FFF_FFFF;
        corner[3] = 32'h8000_0000;
        corner[4] = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_compares();
        t_addsub();
        t_carry();
        t_overflow();
        t_dec();
        t_sign();
        t_imm();
        t_illegal();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule